// File: doc/BRIEF.md
# Timer Input Capture Unit

This block takes a timestamp from one of four free-running 16-bit timers whenever a qualifying event is seen on an asynchronous capture pin. The pin is first brought into the clock domain by a two-stage synchronizer. An edge detector then compares each synchronized sample with the one before it. A mode field chooses what counts as an event: a single falling edge, a single rising edge, or one rising edge out of every four or every sixteen.

On an event the selected timer's value is stored in a 16-bit holding register, and a sticky interrupt flag is raised. The flag stays up until software clears it. If a new capture arrives before the old one has been collected, the new value simply replaces the old one, and no overrun status is kept. A port-write strobe can also force a capture. This covers the case where the pin is driven as an output and a write to it must still record a timestamp. The timers must run from the same clock as the block.

Top module: `cap_unit`

## Requirements
- R1: A pin transition that is set up before clock edge n is synchronized and qualified so that the capture happens at edge n+2. The holding register takes the timer value present at edge n+2, and the flag reads 1 after that same edge.
- R2: The mode value 4'b0100 captures on every falling edge of the pin and ignores rising edges. The mode value 4'b0101 captures on every rising edge and ignores falling edges.
- R3: The mode value 4'b0110 captures on the 4th, 8th, 12th and later multiples-of-4 rising edges. The mode value 4'b0111 captures on every 16th rising edge. In both modes the count starts from zero after reset.
- R4: Any mode value other than 4'b0100 through 4'b0111 disables capture. Neither the pin nor the port-write strobe changes the holding register or the flag, and the prescale count is held at zero.
- R5: The timer select value s (0 to 3) picks bits [16*s+15:16*s] of the concatenated timer bus as the value to capture.
- R6: Every capture sets the flag. The flag stays set until a clear pulse is given. A clear pulse in a cycle with no capture leaves the flag at 0 after the edge.
- R7: If a clear pulse and a capture fall in the same cycle, the flag is 1 after that edge.
- R8: A second capture made without any clear overwrites the held value. There is no indication that this happened, and the flag simply stays at 1.
- R9: In an enabled mode, a port-write strobe that is high at a clock edge captures at that same edge, with no synchronizer delay.
- R10: Any change of the mode value resets the prescale count to zero, and a pin edge seen in the cycle of the change is not counted. A partial count from an earlier mode therefore cannot cause an early capture.
- R11: While no capture occurs, the holding register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, shared with the timers |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_pin_i | input | 1 | Asynchronous capture pin |
| mode_i | input | 4 | Event mode select |
| tsel_i | input | 2 | Timer source select |
| tmr_i | input | 64 | Four 16-bit timer counts, timer s in bits [16*s+15:16*s] |
| port_wr_i | input | 1 | Port write strobe that forces a capture |
| clr_i | input | 1 | Flag clear pulse |
| cap_val_o | output | 16 | Captured timer value |
| cap_flag_o | output | 1 | Sticky capture interrupt flag |

## Verification
The hardest situation to reach is a divide-by-4 or divide-by-16 prescaler that is interrupted partway through its count by a change of mode. The bench counts two rising edges in divide-by-4 mode and then switches to divide-by-16 and back. It expects that the next three edges produce nothing and that the fourth edge captures. The clear/capture collision is produced by raising the clear pulse and the port-write strobe in the same cycle. A full sweep of all sixteen mode values against all four timer sources checks the edge qualification against a count of rising edges kept in the bench.

// File: rtl/cap_pkg.sv
package cap_pkg;
    localparam int MODE_W = 4;
    localparam int PS_W   = 4;

    localparam logic [MODE_W-1:0] MODE_OFF    = 4'b0000;
    localparam logic [MODE_W-1:0] MODE_FALL   = 4'b0100;
    localparam logic [MODE_W-1:0] MODE_RISE   = 4'b0101;
    localparam logic [MODE_W-1:0] MODE_RISE4  = 4'b0110;
    localparam logic [MODE_W-1:0] MODE_RISE16 = 4'b0111;

    localparam logic [PS_W-1:0] LAST4  = PS_W'(3);
    localparam logic [PS_W-1:0] LAST16 = PS_W'(15);

    typedef struct packed {
        logic              prev;
        logic [MODE_W-1:0] mode;
        logic [PS_W-1:0]   cnt;
    } qual_st_t;

    function automatic logic mode_enabled(input logic [MODE_W-1:0] m);
        return (m == MODE_FALL) || (m == MODE_RISE) ||
               (m == MODE_RISE4) || (m == MODE_RISE16);
    endfunction
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/cap_qual.sv
module cap_qual
    import cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              port_wr_i,
    output logic              evt_o
);
    qual_st_t st_d, st_q;
    logic rise, fall, chg, pin_hit;

    always_comb begin
        st_d      = st_q;
        st_d.prev = smp_i;
        st_d.mode = mode_i;
        rise      = smp_i & ~st_q.prev;
        fall      = ~smp_i & st_q.prev;
        chg       = (mode_i != st_q.mode);
        pin_hit   = 1'b0;
        case (mode_i)
            MODE_FALL: begin
                pin_hit  = fall;
                st_d.cnt = '0;
            end
            MODE_RISE: begin
                pin_hit  = rise;
                st_d.cnt = '0;
            end
            MODE_RISE4: begin
                if (rise) begin
                    if (st_q.cnt >= LAST4) begin
                        pin_hit  = 1'b1;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            MODE_RISE16: begin
                if (rise) begin
                    if (st_q.cnt >= LAST16) begin
                        pin_hit  = 1'b1;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
            end
            default: st_d.cnt = '0;
        endcase
        if (chg) begin
            pin_hit  = 1'b0;
            st_d.cnt = '0;
        end
        evt_o = mode_enabled(mode_i) & (pin_hit | port_wr_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.prev <= 1'b0;
            st_q.mode <= MODE_OFF;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/cap_tsel.sv
module cap_tsel #(
    parameter int TMR_W = 16,
    parameter int N_TMR = 4,
    localparam int SEL_W = $clog2(N_TMR)
) (
    input  logic [N_TMR*TMR_W-1:0] tmr_i,
    input  logic [SEL_W-1:0]       sel_i,
    output logic [TMR_W-1:0]       val_o
);
    logic [TMR_W-1:0] lane [N_TMR];

    for (genvar g = 0; g < N_TMR; g++) begin : g_lane
        assign lane[g] = tmr_i[g*TMR_W +: TMR_W];
    end

    always_comb begin
        val_o = '0;
        for (int i = 0; i < N_TMR; i++) begin
            if (sel_i == SEL_W'(i)) val_o = lane[i];
        end
    end
endmodule

// File: rtl/cap_unit.sv
module cap_unit
    import cap_pkg::*;
#(
    parameter int TMR_W = 16,
    parameter int N_TMR = 4,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W = $clog2(N_TMR)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cap_pin_i,
    input  logic [MODE_W-1:0]      mode_i,
    input  logic [SEL_W-1:0]       tsel_i,
    input  logic [N_TMR*TMR_W-1:0] tmr_i,
    input  logic                   port_wr_i,
    input  logic                   clr_i,
    output logic [TMR_W-1:0]       cap_val_o,
    output logic                   cap_flag_o
);
    typedef struct packed {
        logic [TMR_W-1:0] val;
        logic             flag;
    } hold_st_t;

    logic             smp;
    logic             cap_evt;
    logic [TMR_W-1:0] tsel_val;
    hold_st_t         hs_d, hs_q;

    cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk), .rst_n (rst_n), .d_i (cap_pin_i), .q_o (smp)
    );

    cap_qual u_qual (
        .clk (clk), .rst_n (rst_n), .smp_i (smp), .mode_i (mode_i),
        .port_wr_i (port_wr_i), .evt_o (cap_evt)
    );

    cap_tsel #(.TMR_W(TMR_W), .N_TMR(N_TMR)) u_tsel (
        .tmr_i (tmr_i), .sel_i (tsel_i), .val_o (tsel_val)
    );

    always_comb begin
        hs_d = hs_q;
        if (clr_i)   hs_d.flag = 1'b0;
        if (cap_evt) begin
            hs_d.val  = tsel_val;
            hs_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hs_q <= '0;
        else        hs_q <= hs_d;
    end

    assign cap_val_o  = hs_q.val;
    assign cap_flag_o = hs_q.flag;
endmodule

// File: rtl/cap_unit_chk.sv
module cap_unit_chk #(
    parameter int TMR_W = 16,
    parameter int N_TMR = 4,
    localparam int SEL_W = $clog2(N_TMR)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [3:0]             mode_i,
    input logic [SEL_W-1:0]       tsel_i,
    input logic [N_TMR*TMR_W-1:0] tmr_i,
    input logic                   port_wr_i,
    input logic                   clr_i,
    input logic [TMR_W-1:0]       cap_val_o,
    input logic                   cap_flag_o,
    input logic                   cap_evt
);
    logic [TMR_W-1:0] sel_now;
    logic             en_now;
    assign sel_now = tmr_i[tsel_i*TMR_W +: TMR_W];
    assign en_now  = (mode_i[3:2] == 2'b01);

    AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> cap_flag_o);                                   // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_flag_o && !clr_i) |=> cap_flag_o);                    // R6
    AST_CLR_WINS_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !cap_evt) |=> !cap_flag_o);                      // R6
    AST_COLLIDE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && cap_evt) |=> cap_flag_o);                        // R7
    AST_VAL_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (cap_val_o == $past(sel_now)));                // R5
    AST_VAL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_evt |=> $stable(cap_val_o));                          // R11
    AST_OFF_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        !en_now |-> !cap_evt);                                     // R4
    AST_PORT_WR_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        (en_now && port_wr_i) |-> cap_evt);                        // R9
endmodule

bind cap_unit cap_unit_chk #(.TMR_W(TMR_W), .N_TMR(N_TMR)) u_chk (
    .clk (clk), .rst_n (rst_n), .mode_i (mode_i), .tsel_i (tsel_i),
    .tmr_i (tmr_i), .port_wr_i (port_wr_i), .clr_i (clr_i),
    .cap_val_o (cap_val_o), .cap_flag_o (cap_flag_o), .cap_evt (cap_evt)
);

// File: tb/tb_cap_unit.sv
module tb_cap_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin = 1'b0;
    logic [3:0]  mode = 4'd0;
    logic [1:0]  tsel = 2'd0;
    logic [63:0] tmr;
    logic        port_wr = 1'b0;
    logic        clr = 1'b0;
    logic [15:0] val;
    logic        flag;
    logic [15:0] cnt = 16'd0;
    logic [15:0] held = 16'd0;
    logic [15:0] expv;
    int checks = 0;
    int fails = 0;

    always #4 clk = ~clk;

    always @(negedge clk) cnt <= cnt + 16'd1;

    for (genvar k = 0; k < 4; k++) begin : g_tmr
        assign tmr[k*16 +: 16] = cnt * 16'(2*k+1) + 16'(k * 16'h1111);
    end

    cap_unit dut (
        .clk (clk), .rst_n (rst_n), .cap_pin_i (pin), .mode_i (mode),
        .tsel_i (tsel), .tmr_i (tmr), .port_wr_i (port_wr), .clr_i (clr),
        .cap_val_o (val), .cap_flag_o (flag)
    );

    function automatic logic [15:0] lane(input logic [1:0] s);
        return tmr[s*16 +: 16];
    endfunction

    task automatic chk(input logic ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_flag();
        @(negedge clk) clr = 1'b1;
        @(negedge clk) clr = 1'b0;
    endtask

    // drive pin, expect capture at the second edge after the sampling edge
    task automatic pin_edge(input logic v, input logic cap, input string req);
        @(negedge clk) pin = v;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        #1 expv = lane(tsel);
        @(negedge clk);
        if (cap) begin
            chk(flag === 1'b1, req, {15'd0, flag}, 16'd1);
            chk(val === expv, req, val, expv);
            held = expv;
        end else begin
            chk(flag === 1'b0, req, {15'd0, flag}, 16'd0);
            chk(val === held, req, val, held);
        end
        if (cap) clear_flag();
    endtask

    task automatic set_mode(input logic [3:0] m);
        @(negedge clk) mode = m;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(flag === 1'b0, "reset flag", {15'd0, flag}, 16'd0);
        chk(val === 16'd0, "reset value", val, 16'd0);

        // R1 R2 R3 R4 R5: sweep of all mode values against all timer sources
        for (int s = 0; s < 4; s++) begin
            for (int m = 0; m < 16; m++) begin
                tsel = 2'(s);
                set_mode(4'(m));
                clear_flag();
                for (int i = 1; i <= 17; i++) begin
                    pin_edge(1'b1, (m == 5) || (m == 6 && i % 4 == 0) ||
                                   (m == 7 && i % 16 == 0), "R1/R2/R3/R5 rise");
                    pin_edge(1'b0, (m == 4), "R2/R4 fall");
                end
            end
        end

        // R9: port write captures at the same edge
        tsel = 2'd2;
        set_mode(4'b0101);
        clear_flag();
        @(negedge clk) port_wr = 1'b1;
        #1 expv = lane(tsel);
        @(negedge clk) port_wr = 1'b0;
        chk(flag === 1'b1, "R9 flag", {15'd0, flag}, 16'd1);
        chk(val === expv, "R9 value", val, expv);
        held = expv;

        // R6: flag holds without clear
        repeat (5) @(negedge clk);
        chk(flag === 1'b1, "R6 hold", {15'd0, flag}, 16'd1);
        chk(val === held, "R11 held value", val, held);

        // R8: overwrite without clear
        repeat (3) @(negedge clk);
        @(negedge clk) port_wr = 1'b1;
        #1 expv = lane(tsel);
        @(negedge clk) port_wr = 1'b0;
        chk(val === expv, "R8 overwrite", val, expv);
        chk(flag === 1'b1, "R8 flag", {15'd0, flag}, 16'd1);
        held = expv;

        // R7: clear and capture together
        @(negedge clk) begin port_wr = 1'b1; clr = 1'b1; end
        @(negedge clk) begin port_wr = 1'b0; clr = 1'b0; end
        chk(flag === 1'b1, "R7 collide", {15'd0, flag}, 16'd1);
        held = val;

        // R6: clear alone
        clear_flag();
        chk(flag === 1'b0, "R6 clear", {15'd0, flag}, 16'd0);

        // R4: port write ignored when disabled
        set_mode(4'b1100);
        @(negedge clk) port_wr = 1'b1;
        @(negedge clk) port_wr = 1'b0;
        chk(flag === 1'b0, "R4 flag", {15'd0, flag}, 16'd0);
        chk(val === held, "R4 value", val, held);

        // R10: mode change discards partial prescale count
        tsel = 2'd1;
        set_mode(4'b0110);
        pin_edge(1'b1, 1'b0, "R10 rise1");
        pin_edge(1'b0, 1'b0, "R10 fall");
        pin_edge(1'b1, 1'b0, "R10 rise2");
        pin_edge(1'b0, 1'b0, "R10 fall");
        set_mode(4'b0111);
        set_mode(4'b0110);
        for (int i = 1; i <= 4; i++) begin
            pin_edge(1'b1, i == 4, "R10 recount");
            pin_edge(1'b0, 1'b0, "R10 fall");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule